// File: doc/BRIEF.md
# Vertical Blanking Window Controller

This block decides, one video line at a time, how the luma and chroma paths of a decoder treat the lines around vertical blanking. It watches a 5-bit line identifier that an upstream sequencer advances once per line. A window flag opens on a line fixed by the selected video standard. It closes after a programmed number of lines, or earlier if the vertical blanking input is high when a new line begins. Lines outside the blanking region always pass through normally.

Inside the blanking region, one mode bit applies while the window is open and a second mode bit applies while both the window and blanking are low. Together with the window flag, these bits select normal, simplified or black processing for each path. All outputs change on the first clock of a new line identifier and hold steady until the next change. The downstream filter and output matrix read the two per-path codes.

Top module: `vblank_window_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `win_flag` low and both mode outputs at 00.
- R2: A new line whose identifier is the opening line (02 when `std_pal` is 1, 03 when it is 0), arriving with `vblank` low, sets `win_flag` high and starts the line count at one.
- R3: Once open, the window stays high for max(`win_len`,1) lines, counting the opening line, and goes low on the following line.
- R4: If `vblank` is high on the first clock of a new line inside the region, the window is low for that line, whether it was open or about to open.
- R5: The blanking region is identifiers 02 to 0A in PAL and 03 to 06 in NTSC. On any line outside it, `win_flag` is low.
- R6: Mode codes are 00 normal, 01 simplified and 10 black, and 11 never appears. On lines outside the region, both paths are 00, whatever the mode bits are.
- R7: While the window is high, `mode_in`=0 gives 01 on both paths and `mode_in`=1 gives 10 on both paths.
- R8: In the region with the window low and `vblank` low, `mode_out`=0 gives 10 on both paths. `mode_out`=1 gives luma 01 and chroma 10.
- R9: In the region with the window low and `vblank` high, both paths are 00.
- R10: Outputs update only one cycle after the first clock of a new identifier. The first clock after reset counts as a new identifier. Changes to `vblank`, `win_len`, `std_pal` or the mode bits in the middle of a line leave the outputs unchanged until the next identifier change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_id | input | 5 | Current line identifier |
| vblank | input | 1 | Vertical blanking flag |
| std_pal | input | 1 | 1 selects PAL line numbering, 0 selects NTSC |
| win_len | input | 5 | Programmed window length in lines |
| mode_in | input | 1 | Treatment select while the window is high |
| mode_out | input | 1 | Treatment select in the region while the window and blanking are low |
| win_flag | output | 1 | Vertical window flag |
| luma_mode | output | 2 | Luma path code |
| chroma_mode | output | 2 | Chroma path code |

## Verification
The hardest cases to reach are the ones where the window closes on its count before the region ends. A length of zero or one is one such case. The other is blanking rising on the very line the window would open. Both need the programmed length, the blanking line and the standard to line up within the same field. Random fields pick a length, a blanking line and a standard for each field, and short directed fields pin down the zero length, the full-length run to the end of the region, and blanking on the opening line. Each line is also held for a random number of clocks while the control inputs are scrambled mid-line, to show that nothing moves until the identifier changes.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

    localparam int LINE_ID_W = 5;

    localparam int PAL_OPEN_ID  = 2;
    localparam int PAL_LAST_ID  = 10;
    localparam int NTSC_OPEN_ID = 3;
    localparam int NTSC_LAST_ID = 6;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_SIMPLE = 2'b01,
        PM_BLACK  = 2'b10
    } path_mode_e;

    typedef struct packed {
        logic in_region;
        logic is_open;
    } line_class_t;

    typedef struct packed {
        path_mode_e luma;
        path_mode_e chroma;
    } path_pair_t;

    // Classify a line identifier against the blanking region of a standard.
    function automatic line_class_t classify_line(int unsigned id, logic pal);
        line_class_t c;
        int unsigned first_id;
        int unsigned last_id;
        first_id    = pal ? PAL_OPEN_ID : NTSC_OPEN_ID;
        last_id     = pal ? PAL_LAST_ID : NTSC_LAST_ID;
        c.in_region = (id >= first_id) && (id <= last_id);
        c.is_open   = (id == first_id);
        return c;
    endfunction

    // Per-path treatment for one line.
    function automatic path_pair_t select_modes(line_class_t cls, logic win,
                                                logic vb, logic mi, logic mo);
        path_pair_t p;
        if (!cls.in_region) begin
            p.luma   = PM_NORMAL;
            p.chroma = PM_NORMAL;
        end else if (win) begin
            p.luma   = mi ? PM_BLACK : PM_SIMPLE;
            p.chroma = mi ? PM_BLACK : PM_SIMPLE;
        end else if (vb) begin
            p.luma   = PM_NORMAL;
            p.chroma = PM_NORMAL;
        end else begin
            p.luma   = mo ? PM_SIMPLE : PM_BLACK;
            p.chroma = PM_BLACK;
        end
        return p;
    endfunction

endpackage

// File: rtl/vbw_line_tracker.sv
module vbw_line_tracker
    import vbw_pkg::*;
#(
    parameter int ID_W = LINE_ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] line_id,
    input  logic            std_pal,
    output logic            new_line,
    output line_class_t     cls
);

    logic [ID_W-1:0] prev_q;
    logic            seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= line_id;
            seen_q <= 1'b1;
        end
    end

    assign new_line = !seen_q || (line_id != prev_q);

    always_comb begin
        cls = classify_line(32'(line_id), std_pal);
    end

endmodule

// File: rtl/vbw_window_fsm.sv
module vbw_window_fsm
    import vbw_pkg::*;
#(
    parameter int ID_W = LINE_ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            new_line,
    input  line_class_t     cls,
    input  logic            vblank,
    input  logic [ID_W-1:0] win_len,
    output logic            win_nxt,
    output logic            win_q
);

    localparam int CNT_W = ID_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        win_nxt = win_q;
        cnt_nxt = cnt_q;
        if (new_line) begin
            if (!cls.in_region) begin
                win_nxt = 1'b0;
            end else if (cls.is_open) begin
                win_nxt = !vblank;
                cnt_nxt = CNT_W'(1);
            end else if (win_q) begin
                if (vblank || (cnt_q >= win_len)) begin
                    win_nxt = 1'b0;
                end else begin
                    cnt_nxt = cnt_q + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            win_q <= win_nxt;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/vbw_mode_sel.sv
module vbw_mode_sel
    import vbw_pkg::*;
#(
    parameter int N_PATH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        new_line,
    input  line_class_t cls,
    input  logic        win_nxt,
    input  logic        vblank,
    input  logic        mode_in,
    input  logic        mode_out,
    output path_pair_t  modes
);

    path_pair_t pair_d;
    path_mode_e pm_d [N_PATH];
    path_mode_e pm_q [N_PATH];

    always_comb begin
        pair_d   = select_modes(cls, win_nxt, vblank, mode_in, mode_out);
        pm_d[0]  = pair_d.luma;
        pm_d[1]  = pair_d.chroma;
    end

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        always_ff @(posedge clk) begin
            if (rst) begin
                pm_q[g] <= PM_NORMAL;
            end else if (new_line) begin
                pm_q[g] <= pm_d[g];
            end
        end
    end

    assign modes.luma   = pm_q[0];
    assign modes.chroma = pm_q[1];

endmodule

// File: rtl/vblank_window_ctrl.sv
module vblank_window_ctrl
    import vbw_pkg::*;
#(
    parameter int ID_W = LINE_ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] line_id,
    input  logic            vblank,
    input  logic            std_pal,
    input  logic [ID_W-1:0] win_len,
    input  logic            mode_in,
    input  logic            mode_out,
    output logic            win_flag,
    output logic [1:0]      luma_mode,
    output logic [1:0]      chroma_mode
);

    logic        new_line;
    line_class_t cls;
    logic        win_nxt;
    logic        win_q;
    path_pair_t  modes;

    vbw_line_tracker #(.ID_W(ID_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .line_id  (line_id),
        .std_pal  (std_pal),
        .new_line (new_line),
        .cls      (cls)
    );

    vbw_window_fsm #(.ID_W(ID_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .new_line (new_line),
        .cls      (cls),
        .vblank   (vblank),
        .win_len  (win_len),
        .win_nxt  (win_nxt),
        .win_q    (win_q)
    );

    vbw_mode_sel #(.N_PATH(2)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .new_line (new_line),
        .cls      (cls),
        .win_nxt  (win_nxt),
        .vblank   (vblank),
        .mode_in  (mode_in),
        .mode_out (mode_out),
        .modes    (modes)
    );

    assign win_flag    = win_q;
    assign luma_mode   = modes.luma;
    assign chroma_mode = modes.chroma;

endmodule

// File: rtl/vbw_checker.sv
module vbw_checker
    import vbw_pkg::*;
#(
    parameter int ID_W = LINE_ID_W
) (
    input logic            clk,
    input logic            rst,
    input logic [ID_W-1:0] line_id,
    input logic            vblank,
    input logic            std_pal,
    input logic            win_flag,
    input logic [1:0]      luma_mode,
    input logic [1:0]      chroma_mode
);

    logic [ID_W-1:0] chk_prev;
    logic            chk_seen;
    logic            chk_nl;
    line_class_t     chk_cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_prev <= '0;
            chk_seen <= 1'b0;
        end else begin
            chk_prev <= line_id;
            chk_seen <= 1'b1;
        end
    end

    assign chk_nl  = !chk_seen || (line_id != chk_prev);
    assign chk_cls = classify_line(32'(line_id), std_pal);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!win_flag && luma_mode == 2'b00 && chroma_mode == 2'b00)); // R1

    AST_OPEN_LINE: assert property (@(posedge clk) disable iff (rst)
        (chk_nl && chk_cls.is_open && !vblank) |=> win_flag); // R2

    AST_VBLANK_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (chk_nl && chk_cls.in_region && vblank) |=> !win_flag); // R4

    AST_OUTSIDE_REGION: assert property (@(posedge clk) disable iff (rst)
        (chk_nl && !chk_cls.in_region)
        |=> (!win_flag && luma_mode == 2'b00 && chroma_mode == 2'b00)); // R5

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        (luma_mode != 2'b11) && (chroma_mode != 2'b11)); // R6

    AST_WINDOW_PAIR: assert property (@(posedge clk) disable iff (rst)
        win_flag |-> (luma_mode == chroma_mode && luma_mode != 2'b00)); // R7

    AST_MIDLINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (chk_seen && !chk_nl)
        |=> ($stable(win_flag) && $stable(luma_mode) && $stable(chroma_mode))); // R10

endmodule

bind vblank_window_ctrl vbw_checker #(.ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_id     (line_id),
    .vblank      (vblank),
    .std_pal     (std_pal),
    .win_flag    (win_flag),
    .luma_mode   (luma_mode),
    .chroma_mode (chroma_mode)
);

// File: tb/vblank_window_ctrl_tb.sv
module vblank_window_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] line_id = '0;
    logic       vblank = 1'b0;
    logic       std_pal = 1'b1;
    logic [4:0] win_len = '0;
    logic       mode_in = 1'b0;
    logic       mode_out = 1'b0;
    logic       win_flag;
    logic [1:0] luma_mode;
    logic [1:0] chroma_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    bit         m_seen;
    logic [4:0] m_prev;
    bit         m_win;
    int         m_cnt;
    logic [4:0] m_exp;
    string      m_tag;

    always #4 clk = ~clk;

    vblank_window_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_id     (line_id),
        .vblank      (vblank),
        .std_pal     (std_pal),
        .win_len     (win_len),
        .mode_in     (mode_in),
        .mode_out    (mode_out),
        .win_flag    (win_flag),
        .luma_mode   (luma_mode),
        .chroma_mode (chroma_mode)
    );

    function automatic bit in_reg(int id, bit pal);
        return pal ? (id >= 2 && id <= 10) : (id >= 3 && id <= 6);
    endfunction

    function automatic logic [3:0] exp_modes(bit reg_hit, bit w, bit vb, bit mi, bit mo);
        if (!reg_hit) return 4'b0000;
        if (w)        return mi ? 4'b1010 : 4'b0101;
        if (vb)       return 4'b0000;
        return mo ? 4'b0110 : 4'b1010;
    endfunction

    task automatic model_step(int id, bit vb, bit pal, int len, bit mi, bit mo);
        bit r;
        r = in_reg(id, pal);
        if (!r) begin
            m_win = 0; m_tag = "R5,R6";
        end else if (id == (pal ? 2 : 3)) begin
            if (vb) begin m_win = 0; m_tag = "R4"; end
            else begin m_win = 1; m_cnt = 1; m_tag = "R2/R7"; end
        end else if (m_win) begin
            if (vb) begin m_win = 0; m_tag = "R4"; end
            else if (m_cnt >= len) begin m_win = 0; m_tag = "R3"; end
            else begin m_cnt++; m_tag = "R3/R7"; end
        end else begin
            m_tag = vb ? "R9" : "R8";
        end
        m_exp = {m_win, exp_modes(r, m_win, vb, mi, mo)};
    endtask

    task automatic check(string tag, logic [4:0] exp);
        logic [4:0] act;
        act = {win_flag, luma_mode, chroma_mode};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got win/luma/chroma=%b expected %b", tag, act, exp);
        end
    endtask

    // Called at a negedge; leaves at a negedge.
    task automatic drive_line(int id, bit vb, bit pal, int len, bit mi, bit mo, int hold);
        bit is_new;
        is_new   = !m_seen || (5'(id) != m_prev);
        line_id  = 5'(id);
        vblank   = vb;
        std_pal  = pal;
        win_len  = 5'(len);
        mode_in  = mi;
        mode_out = mo;
        if (is_new) model_step(id, vb, pal, len, mi, mo);
        else m_tag = "R10";
        m_seen = 1; m_prev = 5'(id);
        @(negedge clk);
        check(m_tag, m_exp);
        for (int k = 1; k < hold; k++) begin
            vblank   = 1'($urandom);
            mode_in  = 1'($urandom);
            mode_out = 1'($urandom);
            win_len  = 5'($urandom);
            std_pal  = 1'($urandom);
            @(negedge clk);
            check("R10", m_exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 5'b00000);
        rst = 1'b0;
        m_seen = 0; m_win = 0; m_cnt = 0; m_exp = '0; m_prev = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // PAL, zero length: one window line (R3)
        for (int id = 0; id < 6; id++) drive_line(id, 0, 1, 0, 0, 1, 1);
        // NTSC, long length: window to end of region (R3, R7 black)
        for (int id = 0; id < 9; id++) drive_line(id, 0, 0, 31, 1, 0, 2);
        // PAL, blanking high on opening line (R4, R9)
        for (int id = 0; id < 5; id++) drive_line(id, id >= 2, 1, 5, 0, 0, 1);
        // PAL, jump into region skipping the opening line (R8)
        drive_line(0, 0, 1, 5, 0, 0, 1);
        drive_line(6, 0, 1, 5, 0, 1, 1);
        drive_line(6, 0, 1, 5, 0, 0, 3);   // repeated identifier: R10
        // Identifiers above the region table (R5, R6)
        for (int id = 24; id < 32; id++) drive_line(id, 1'($urandom), 1, 3, 1, 1, 1);
        // Reset in the middle of an open window (R1)
        for (int id = 0; id < 4; id++) drive_line(id, 0, 1, 6, 1, 0, 1);
        do_reset();

        // Random fields
        for (int f = 0; f < 60; f++) begin
            bit pal;
            int len;
            int vbl;
            pal = 1'($urandom);
            len = $urandom % 13;
            vbl = $urandom % 26;
            for (int id = 0; id < 24; id++)
                drive_line(id, id >= vbl, pal, len, 1'($urandom), 1'($urandom),
                           1 + ($urandom % 3));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule